// File: doc/BRIEF.md
# Two-Dimensional Dual-Estimator CFAR Detector

This block decides, for every cell of a range-doppler energy map, whether the cell holds a target or only noise and clutter. A whole map is first streamed into a frame store that the block owns, one unsigned energy value per accepted transfer. The address is the doppler index times the number of range columns plus the range index, so the range index runs fastest. Once the last cell has been stored, the block walks the map in the same order. For each cell under test it reads a rectangular neighbourhood of 5 doppler rows by 9 range columns. A 3 by 5 guard hole in the middle of that neighbourhood, which contains the cell under test, is left out. The remaining 30 cells form the training set.

Two noise estimators run side by side on the training set. The averaging estimator uses the mean, and compares cell x 30 with scale x sum so that no divider is needed. The ranked estimator inserts the training values one per cycle into a descending sorted register array and picks the value of rank N. Each estimator is multiplied by its own unsigned Q8.8 scale factor. A cell is reported as a target only when it is strictly above both scaled estimates. The window wraps around the doppler axis. Cells whose window would run past either end of the range axis are always reported as non-targets.

Results leave on a valid/ready stream, one per cell, in load order. While out_valid is high and out_ready is low, the result is held unchanged, and the block does no further work until the result is taken. The input side only accepts data in the load phase. in_ready is low for the whole time the block is evaluating a frame. The rank and scale inputs are plain control pins and must be held steady while a frame is evaluated.

Top module: `cfar2d_detector`

## Requirements
- R1: After reset, and again after each frame, in_ready is high and out_valid is low. Each transfer with in_valid and in_ready high stores in_data at the next linear address: doppler x COLS + range, with range fastest. After ROWS x COLS transfers, in_ready drops and stays low until the frame has been fully reported.
- R2: Exactly one result is produced per cell, in the same order as the load. out_doppler and out_range carry the coordinates of the cell.
- R3: While out_valid is high and out_ready is low, out_valid stays high and out_doppler, out_range and out_detect keep their values on the next cycle.
- R4: The training set is the 5 (doppler) by 9 (range) window centred on the cell, minus the centred 3 by 5 guard window. The cell itself is excluded, which leaves 30 cells.
- R5: The averaging test passes when cell x 30 x 256 > ca_scale x (sum of the training cells). ca_scale is unsigned Q8.8. Equality fails the test.
- R6: The ranked test passes when cell x 256 > os_scale x V. V is the training value of rank N in descending order, where rank 1 is the largest. os_scale is unsigned Q8.8. Equality fails the test.
- R7: An os_rank of 0 is treated as rank 1, and an os_rank above 30 is treated as rank 30.
- R8: out_detect is the AND of the averaging and ranked tests.
- R9: Training rows wrap circularly along the doppler axis. Row -1 is row ROWS-1, and row ROWS is row 0.
- R10: A cell whose range index is below 4 or above COLS-5 is reported with out_detect low.
- R11: Both comparisons use full-width products and sums. Values up to 2^32-1 and scales up to 0xFFFF give exact results.
- R12: frame_done is high for exactly one cycle: the cycle right after the handshake of the last cell. In that same cycle in_ready is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load stream: data valid |
| in_ready | output | 1 | Load stream: block accepts data (load phase only) |
| in_data | input | DW | Energy value of the next cell |
| os_rank | input | $clog2(NT+1) | Rank N for the ranked estimator (1 = largest) |
| ca_scale | input | SW | Q8.8 scale for the averaging estimator |
| os_scale | input | SW | Q8.8 scale for the ranked estimator |
| out_valid | output | 1 | Result stream: result valid |
| out_ready | input | 1 | Result stream: consumer accepts result |
| out_doppler | output | $clog2(ROWS) | Doppler index of the result |
| out_range | output | $clog2(COLS) | Range index of the result |
| out_detect | output | 1 | 1 = target, 0 = noise or clutter |
| frame_done | output | 1 | One-cycle pulse after the last result |

## Verification
The bench targets the cell rows at the top and bottom of the map, whose training rows come from the far side. A design that clamped or zero-filled there instead of wrapping would give the wrong decisions on those rows. Flat maps, where the cell equals its estimate, catch a comparison that is not strict. Those maps would then report targets everywhere. Near-full-scale energies with scales close to unity catch any product or sum that is cut short; such a design would give decisions that look random. The bench also sets rank to 0 and above 30, and picks scale pairs where only one of the two tests passes. These catch a rank that is not clamped, a rank that is off by one, and an OR used where an AND is needed. Random back-pressure checks that a result that has not been taken never changes.

// File: rtl/cfar_pkg.sv
package cfar_pkg;
  typedef enum logic [2:0] {
    ST_FILL,
    ST_START,
    ST_GATHER,
    ST_DRAIN,
    ST_OUT
  } cfar_state_e;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_TRAIN,
    RD_CUT
  } rd_kind_e;
endpackage

// File: rtl/cfar_frame_mem.sv
module cfar_frame_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/cfar_os_sort.sv
module cfar_os_sort #(
  parameter int DW  = 32,
  parameter int N   = 30,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          ins_en,
  input  logic [DW-1:0] ins_data,
  input  logic [IW-1:0] sel_idx,
  output logic [DW-1:0] sel_data
);
  logic [DW-1:0] ent [N];
  logic [DW-1:0] nxt [N];
  logic [N-1:0]  gt;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign gt[i] = ins_data > ent[i];
    if (i == 0) begin : g_head
      assign nxt[i] = gt[i] ? ins_data : ent[i];
    end else begin : g_body
      assign nxt[i] = gt[i] ? (gt[i-1] ? ent[i-1] : ins_data) : ent[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int i = 0; i < N; i++) ent[i] <= '0;
    end else if (ins_en) begin
      for (int i = 0; i < N; i++) ent[i] <= nxt[i];
    end
  end

  assign sel_data = ent[sel_idx];
endmodule

// File: rtl/cfar_decide.sv
module cfar_decide #(
  parameter int DW   = 32,
  parameter int SW   = 16,
  parameter int NT   = 30,
  parameter int FRAC = 8,
  parameter int SUMW = 37
) (
  input  logic [DW-1:0]   cut,
  input  logic [SUMW-1:0] sum,
  input  logic [DW-1:0]   os_val,
  input  logic [SW-1:0]   ca_scale,
  input  logic [SW-1:0]   os_scale,
  output logic            ca_hit,
  output logic            os_hit
);
  localparam int CAW = SUMW + SW + 1;
  localparam int OSW = DW + SW + 1;

  logic [CAW-1:0] ca_lhs, ca_rhs;
  logic [OSW-1:0] os_lhs, os_rhs;

  always_comb begin
    ca_lhs = (CAW'(cut) * CAW'(NT)) << FRAC;
    ca_rhs = CAW'(ca_scale) * CAW'(sum);
    os_lhs = OSW'(cut) << FRAC;
    os_rhs = OSW'(os_scale) * OSW'(os_val);
    ca_hit = ca_lhs > ca_rhs;
    os_hit = os_lhs > os_rhs;
  end
endmodule

// File: rtl/cfar2d_detector.sv
module cfar2d_detector
  import cfar_pkg::*;
#(
  parameter int DW   = 32,
  parameter int ROWS = 16,
  parameter int COLS = 64,
  parameter int HR   = 2,
  parameter int HC   = 4,
  parameter int GR   = 1,
  parameter int GC   = 2,
  parameter int SW   = 16,
  parameter int FRAC = 8,
  localparam int NT  = (2*HR+1)*(2*HC+1) - (2*GR+1)*(2*GC+1),
  localparam int KW  = $clog2(NT+1),
  localparam int RW  = $clog2(ROWS),
  localparam int CW  = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [KW-1:0] os_rank,
  input  logic [SW-1:0] ca_scale,
  input  logic [SW-1:0] os_scale,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [RW-1:0] out_doppler,
  output logic [CW-1:0] out_range,
  output logic          out_detect,
  output logic          frame_done
);
  localparam int CELLS = ROWS * COLS;
  localparam int AW    = $clog2(CELLS);
  localparam int WR    = 2*HR + 1;
  localparam int WC    = 2*HC + 1;
  localparam int DRW   = $clog2(WR);
  localparam int DCW   = $clog2(WC);
  localparam int IW    = $clog2(NT);
  localparam int SUMW  = DW + $clog2(NT+1);

  cfar_state_e    state;
  logic [AW-1:0]  fill_cnt;
  logic [RW-1:0]  row;
  logic [CW-1:0]  col;
  logic [DRW-1:0] dr;
  logic [DCW-1:0] dc;
  rd_kind_e       kind, kind_q;
  logic [AW-1:0]  rd_addr;
  logic [DW-1:0]  rd_data;
  logic [DW-1:0]  cut_q;
  logic [SUMW-1:0] sum_q;
  logic [DW-1:0]  os_val;
  logic [IW-1:0]  rank_idx;
  logic           ca_hit, os_hit, edge_cell, last_cell, in_fire, done_q;
  int             rr_w, cc_w;

  assign in_ready  = (state == ST_FILL);
  assign in_fire   = in_valid && in_ready;
  assign out_valid = (state == ST_OUT);
  assign edge_cell = (int'(col) < HC) || (int'(col) > COLS - 1 - HC);
  assign last_cell = (row == RW'(ROWS-1)) && (col == CW'(COLS-1));

  // window address with circular doppler index
  always_comb begin
    rr_w = int'(row) + int'(dr) - HR;
    if (rr_w < 0) rr_w = rr_w + ROWS;
    else if (rr_w >= ROWS) rr_w = rr_w - ROWS;
    cc_w = int'(col) + int'(dc) - HC;
    rd_addr = AW'(rr_w * COLS + cc_w);
    if ((int'(dr) == HR) && (int'(dc) == HC)) kind = RD_CUT;
    else if ((int'(dr) >= HR-GR) && (int'(dr) <= HR+GR) &&
             (int'(dc) >= HC-GC) && (int'(dc) <= HC+GC)) kind = RD_NONE;
    else kind = RD_TRAIN;
  end

  always_comb begin
    if (os_rank == '0) rank_idx = '0;
    else if (int'(os_rank) > NT) rank_idx = IW'(NT - 1);
    else rank_idx = IW'(int'(os_rank) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_FILL;
      fill_cnt <= '0;
      row      <= '0;
      col      <= '0;
      dr       <= '0;
      dc       <= '0;
      kind_q   <= RD_NONE;
      cut_q    <= '0;
      sum_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      kind_q <= (state == ST_GATHER) ? kind : RD_NONE;
      if (kind_q == RD_TRAIN) sum_q <= sum_q + SUMW'(rd_data);
      if (kind_q == RD_CUT)   cut_q <= rd_data;
      unique case (state)
        ST_FILL: if (in_fire) begin
          if (fill_cnt == AW'(CELLS-1)) begin
            fill_cnt <= '0;
            row      <= '0;
            col      <= '0;
            state    <= ST_START;
          end else begin
            fill_cnt <= fill_cnt + 1'b1;
          end
        end
        ST_START: begin
          sum_q <= '0;
          cut_q <= '0;
          dr    <= '0;
          dc    <= '0;
          state <= edge_cell ? ST_OUT : ST_GATHER;
        end
        ST_GATHER: begin
          if (dc == DCW'(WC-1)) begin
            dc <= '0;
            if (dr == DRW'(WR-1)) state <= ST_DRAIN;
            else dr <= dr + 1'b1;
          end else begin
            dc <= dc + 1'b1;
          end
        end
        ST_DRAIN: state <= ST_OUT;
        ST_OUT: if (out_ready) begin
          if (last_cell) begin
            state  <= ST_FILL;
            done_q <= 1'b1;
          end else begin
            state <= ST_START;
            if (col == CW'(COLS-1)) begin
              col <= '0;
              row <= row + 1'b1;
            end else begin
              col <= col + 1'b1;
            end
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  cfar_frame_mem #(.DW(DW), .DEPTH(CELLS)) u_mem (
    .clk     (clk),
    .wr_en   (in_fire),
    .wr_addr (fill_cnt),
    .wr_data (in_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  cfar_os_sort #(.DW(DW), .N(NT)) u_sort (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (state == ST_START),
    .ins_en   (kind_q == RD_TRAIN),
    .ins_data (rd_data),
    .sel_idx  (rank_idx),
    .sel_data (os_val)
  );

  cfar_decide #(.DW(DW), .SW(SW), .NT(NT), .FRAC(FRAC), .SUMW(SUMW)) u_dec (
    .cut      (cut_q),
    .sum      (sum_q),
    .os_val   (os_val),
    .ca_scale (ca_scale),
    .os_scale (os_scale),
    .ca_hit   (ca_hit),
    .os_hit   (os_hit)
  );

  assign out_doppler = row;
  assign out_range   = col;
  assign out_detect  = !edge_cell && ca_hit && os_hit;
  assign frame_done  = done_q;
endmodule

// File: rtl/cfar2d_checker.sv
module cfar2d_checker #(
  parameter int ROWS = 16,
  parameter int COLS = 64,
  parameter int HC   = 4,
  parameter int RW   = 4,
  parameter int CW   = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [RW-1:0] out_doppler,
  input logic [CW-1:0] out_range,
  input logic          out_detect,
  input logic          frame_done
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid); // R3
  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_doppler) && $stable(out_range) && $stable(out_detect)); // R3
  AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ((int'(out_range) < HC) || (int'(out_range) > COLS - 1 - HC)) |-> !out_detect); // R10
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R12
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(out_valid && out_ready && (int'(out_doppler) == ROWS - 1) && (int'(out_range) == COLS - 1))); // R12
  AST_DONE_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> in_ready); // R12
endmodule

bind cfar2d_detector cfar2d_checker #(
  .ROWS(ROWS), .COLS(COLS), .HC(HC), .RW(RW), .CW(CW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_doppler (out_doppler),
  .out_range   (out_range),
  .out_detect  (out_detect),
  .frame_done  (frame_done)
);

// File: tb/sim_cfar2d_detector.sv
module sim_cfar2d_detector;
  localparam int ROWS  = 8;
  localparam int COLS  = 24;
  localparam int DW    = 32;
  localparam int NT    = 30;
  localparam int CELLS = ROWS * COLS;
  localparam int RW    = $clog2(ROWS);
  localparam int CW    = $clog2(COLS);
  localparam int KW    = $clog2(NT + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, in_valid, in_ready, out_valid, out_ready, out_detect, frame_done;
  logic [DW-1:0] in_data;
  logic [KW-1:0] os_rank;
  logic [15:0]   ca_scale, os_scale;
  logic [RW-1:0] out_doppler;
  logic [CW-1:0] out_range;

  cfar2d_detector #(.ROWS(ROWS), .COLS(COLS)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .os_rank(os_rank), .ca_scale(ca_scale), .os_scale(os_scale),
    .out_valid(out_valid), .out_ready(out_ready), .out_doppler(out_doppler),
    .out_range(out_range), .out_detect(out_detect), .frame_done(frame_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] frame [CELLS];
  bit exp_det [CELLS];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference decision for one cell, built from R4 to R11
  function automatic bit ref_det(int r, int c, int rank, int cas, int oss);
    logic [31:0] tr [30];
    logic [31:0] t, cut;
    longint unsigned sum;
    int n, k, rr;
    bit ca, os;
    if (c < 4 || c > COLS - 5) return 1'b0;          // R10
    n = 0;
    sum = 0;
    for (int dr = -2; dr <= 2; dr++)
      for (int dc = -4; dc <= 4; dc++) begin
        if (dr >= -1 && dr <= 1 && dc >= -2 && dc <= 2) continue;  // R4 guard
        rr = (r + dr + ROWS) % ROWS;                 // R9 wrap
        tr[n] = frame[rr*COLS + c + dc];
        sum += tr[n];
        n++;
      end
    for (int i = 0; i < 30; i++)
      for (int j = 0; j < 29 - i; j++)
        if (tr[j] < tr[j+1]) begin
          t = tr[j]; tr[j] = tr[j+1]; tr[j+1] = t;
        end
    k = (rank == 0) ? 1 : (rank > 30) ? 30 : rank;   // R7
    cut = frame[r*COLS + c];
    ca = (longint'(cut) * 30 * 256) > (longint'(cas) * longint'(sum));           // R5 R11
    os = (longint'(cut) * 256) > (longint'(oss) * longint'(tr[k-1]));            // R6
    return ca && os;                                 // R8
  endfunction

  function automatic logic [31:0] gen_cell(int mode, int idx);
    int r, c;
    r = idx / COLS;
    c = idx % COLS;
    case (mode)
      1: return 32'd5000;
      4: return ($urandom % 8 == 0) ? 32'hFFFF_FFFF : 32'hF000_0000 + ($urandom % 32'h0100_0000);
      5: begin
        if (r == 0 && c % 2 == 0) return 32'd4000;
        if (r == ROWS - 1 && c % 3 == 0) return 32'd30000;
        return 32'd50 + ($urandom % 10);
      end
      default: return ($urandom % 12 == 0) ? 32'd20000 + ($urandom % 30000) : 32'd100 + ($urandom % 1000);
    endcase
  endfunction

  task automatic run_frame(input int mode, input int rank, input int cas, input int oss,
                           input int rdy_pct, input string tag);
    int idx, got;
    bit hold, want_done;
    logic [RW-1:0] h_r;
    logic [CW-1:0] h_c;
    logic h_d;
    for (int i = 0; i < CELLS; i++) frame[i] = gen_cell(mode, i);
    for (int i = 0; i < CELLS; i++) exp_det[i] = ref_det(i / COLS, i % COLS, rank, cas, oss);
    @(negedge clk);
    os_rank = KW'(rank);
    ca_scale = 16'(cas);
    os_scale = 16'(oss);
    idx = 0;
    while (idx < CELLS) begin
      @(negedge clk);
      in_valid = ($urandom % 4 != 0);
      in_data = frame[idx];
      if (idx == 0 || idx == CELLS - 1) check(in_ready == 1'b1, "R1", "in_ready during load", in_ready, 1);
      if (in_valid && in_ready) idx++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R1", "in_ready after last load", in_ready, 0);
    got = 0;
    hold = 1'b0;
    want_done = 1'b0;
    h_r = '0; h_c = '0; h_d = 1'b0;
    forever begin
      @(negedge clk);
      if (want_done) begin
        check(frame_done == 1'b1, "R12", "frame_done after last result", frame_done, 1);
        check(in_ready == 1'b1, "R12", "in_ready with frame_done", in_ready, 1);
        break;
      end
      if (frame_done) check(1'b0, "R12", "early frame_done", 1, 0);
      if (hold) begin
        check(out_valid && out_doppler == h_r && out_range == h_c && out_detect == h_d,
              "R3", "held result changed", {out_valid, out_doppler, out_range, out_detect},
              {1'b1, h_r, h_c, h_d});
      end
      out_ready = ($urandom % 100) < rdy_pct;
      if (out_valid && out_ready) begin
        check(int'(out_doppler) == got / COLS && int'(out_range) == got % COLS, "R2",
              "result order", int'(out_doppler) * COLS + int'(out_range), got);
        check(out_detect == exp_det[got], ((got % COLS) < 4 || (got % COLS) > COLS - 5) ? "R10" : tag,
              $sformatf("detect at d=%0d r=%0d", got / COLS, got % COLS), out_detect, exp_det[got]);
        got++;
        if (got == CELLS) want_done = 1'b1;
      end
      hold = out_valid && !out_ready;
      h_r = out_doppler; h_c = out_range; h_d = out_detect;
    end
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(20240607));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    os_rank = '0; ca_scale = '0; os_scale = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    check(frame_done == 1'b0, "R12", "reset frame_done", frame_done, 0);
    run_frame(0, 20, 512, 512, 70, "R4 R5 R6 R8");
    run_frame(1, 1, 256, 256, 100, "R5 R6 strict");
    run_frame(2, 0, 256, 256, 60, "R7 rank0");
    run_frame(2, 31, 384, 768, 80, "R7 rank31");
    run_frame(4, 10, 272, 257, 75, "R11");
    run_frame(5, 25, 512, 512, 50, "R9");
    run_frame(0, 5, 128, 1024, 90, "R8 and");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule